// File: doc/BRIEF.md
# Parallel NOR Identification Query Sequencer

This block is a small bus master that finds out which parallel NOR flash sits on a synchronous memory port. A one-cycle `start` request sets it running. It first sends the reset command and reads array word 0, which it keeps as a baseline. It then writes the two unlock cycles and the identification-entry command. Next it reads a vendor code and three device-code words into four output registers. Last, it sends the reset command again and polls word 0 until the value read matches the baseline. A retry limit bounds this poll.

The memory port carries one access at a time. The sequencer holds `memWe` or `memRe`, together with the address and write data, until the memory raises `memAck` for one cycle. Read data is taken in the cycle that `memAck` is high. The parameter `BYTE_MODE` chooses between the native word address map and the map used when a 16-bit part is addressed in bytes. When the query ends, `done` pulses for one cycle. `timedOut` tells whether the poll ran out of retries.

Top module: `nor_id_query`

## Requirements
- R1: After reset, the block makes no memory request, `done` and `timedOut` are low, and all four ID outputs read all ones.
- R2: An accepted start first writes 0x00F0 to setup address A and then reads offset 0. The value read is kept as the baseline. Setup address A is 0x555 in native mode and 0xAAA in byte mode.
- R3: Next the block writes 0x00AA to setup address A, then 0x0055 to setup address B, then 0x0090 to setup address A. Setup address B is 0x2AA in native mode and 0x555 in byte mode.
- R4: The block then reads four words, in this order, into `idVendor`, `idDev0`, `idDev1` and `idDev2`. In native mode the offsets are 0, 1, 0x0E and 0x0F. In byte mode they are 0, 2, 0x1C and 0x1E.
- R5: On an accepted start, all four ID outputs become all ones. Each one changes again only when its own read completes.
- R6: After the ID reads, the block writes 0x00F0 to offset 0 and reads offset 0 repeatedly. On the first read equal to the baseline it stops. `done` goes high for exactly one cycle, in the cycle after that read's acknowledge, and `timedOut` stays low.
- R7: If RETRY_LIMIT poll reads all differ from the baseline, the block stops polling, pulses `done` and sets `timedOut`. A match on the RETRY_LIMIT-th read still counts as success.
- R8: `timedOut` holds its value until the next accepted start, which clears it.
- R9: A start request while a query is in progress is ignored, and the access sequence continues unchanged.
- R10: `memWe` and `memRe` are never high together. A request keeps its kind, address and data stable until it is acknowledged. Outside a query no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Query request, one cycle wide, taken only when idle |
| memAddr | output | ADDR_W | Word offset of the current access |
| memWdata | output | DATA_W | Write data of the current access |
| memWe | output | 1 | Write request, held until acknowledged |
| memRe | output | 1 | Read request, held until acknowledged |
| memRdata | input | DATA_W | Read data, valid while memAck is high |
| memAck | input | 1 | One-cycle completion of the pending access |
| idVendor | output | DATA_W | Vendor code |
| idDev0 | output | DATA_W | First device-code word |
| idDev1 | output | DATA_W | Second device-code word |
| idDev2 | output | DATA_W | Third device-code word |
| done | output | 1 | One-cycle pulse when a query ends |
| timedOut | output | 1 | Return-to-read poll exhausted its retries |

## Verification
The assertions check the port protocol on every cycle:
- a request is held stable until acknowledged, and the two request kinds never overlap;
- `done` lasts a single cycle, and no request is pending when `done` is high;
- `timedOut` only rises together with `done`, and stays set until a start arrives.

Only the bench scenarios can show the rest. These are the exact order of commands and addresses in each mode, the capture of each ID word, and the retry count at which the poll gives up. They also cover the match that lands exactly on the last allowed read, and a start that arrives mid-query without disturbing the sequence.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_RST,
    ST_BASE,
    ST_UNL_A,
    ST_UNL_B,
    ST_AUTO,
    ST_ID0,
    ST_ID1,
    ST_ID2,
    ST_ID3,
    ST_EXIT,
    ST_POLL
  } step_e;

  typedef struct packed {
    step_e      step;
    logic       req;
    logic       isWrite;
    logic       presetIds;
    logic       loadBase;
    logic [3:0] loadId;
    logic       clrCnt;
    logic       incCnt;
    logic       setTo;
    logic       clrTo;
  } ctrl_strb_t;

  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_IDENTRY = 8'h90;

  // Setup addresses: first (A) or second (B), per address map.
  function automatic logic [11:0] setupAddr(input bit byteMode, input bit second);
    logic [11:0] a;
    if (byteMode) a = second ? 12'h555 : 12'hAAA;
    else          a = second ? 12'h2AA : 12'h555;
    return a;
  endfunction

  // ID word offsets; the byte map is the native one doubled.
  function automatic logic [11:0] idOffset(input bit byteMode, input logic [1:0] idx);
    logic [11:0] n;
    case (idx)
      2'd0:    n = 12'h000;
      2'd1:    n = 12'h001;
      2'd2:    n = 12'h00E;
      default: n = 12'h00F;
    endcase
    return byteMode ? (n << 1) : n;
  endfunction

  function automatic logic stepIsWrite(input step_e s);
    return (s == ST_PRE_RST) || (s == ST_UNL_A) || (s == ST_UNL_B) ||
           (s == ST_AUTO) || (s == ST_EXIT);
  endfunction

endpackage

// File: rtl/nor_id_ctrl.sv
module nor_id_ctrl
  import nor_id_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       memAck,
  input  logic       baseMatch,
  input  logic       pollLast,
  output ctrl_strb_t strb,
  output logic       done
);

  step_e curStep, nxtStep;
  logic  doneNxt;

  always_comb begin
    strb      = '0;
    strb.step = curStep;
    nxtStep   = curStep;
    doneNxt   = 1'b0;
    if (curStep == ST_IDLE) begin
      if (start) begin
        strb.presetIds = 1'b1;
        strb.clrCnt    = 1'b1;
        strb.clrTo     = 1'b1;
        nxtStep        = ST_PRE_RST;
      end
    end else begin
      strb.req     = 1'b1;
      strb.isWrite = stepIsWrite(curStep);
      if (memAck) begin
        case (curStep)
          ST_BASE: strb.loadBase = 1'b1;
          ST_ID0:  strb.loadId   = 4'b0001;
          ST_ID1:  strb.loadId   = 4'b0010;
          ST_ID2:  strb.loadId   = 4'b0100;
          ST_ID3:  strb.loadId   = 4'b1000;
          default: ;
        endcase
        if (curStep == ST_POLL) begin
          if (baseMatch) begin
            nxtStep = ST_IDLE;
            doneNxt = 1'b1;
          end else if (pollLast) begin
            strb.setTo = 1'b1;
            nxtStep    = ST_IDLE;
            doneNxt    = 1'b1;
          end else begin
            strb.incCnt = 1'b1;
          end
        end else begin
          nxtStep = step_e'(curStep + 4'd1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curStep <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      curStep <= nxtStep;
      done    <= doneNxt;
    end
  end

endmodule

// File: rtl/nor_id_datapath.sv
module nor_id_datapath
  import nor_id_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter bit BYTE_MODE   = 1'b0,
  parameter int RETRY_LIMIT = 500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctrl_strb_t             strb,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWdata,
  output logic                   memWe,
  output logic                   memRe,
  output logic [3:0][DATA_W-1:0] idWords,
  output logic                   baseMatch,
  output logic                   pollLast,
  output logic                   timedOut
);

  localparam int CNT_W = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_LIMIT - 1);

  logic [DATA_W-1:0] baseline;
  logic [CNT_W-1:0]  pollCnt;
  logic [11:0]       addrSel;
  logic [7:0]        cmdSel;

  always_comb begin
    case (strb.step)
      ST_PRE_RST, ST_UNL_A, ST_AUTO: addrSel = setupAddr(BYTE_MODE, 1'b0);
      ST_UNL_B:                      addrSel = setupAddr(BYTE_MODE, 1'b1);
      ST_ID0:                        addrSel = idOffset(BYTE_MODE, 2'd0);
      ST_ID1:                        addrSel = idOffset(BYTE_MODE, 2'd1);
      ST_ID2:                        addrSel = idOffset(BYTE_MODE, 2'd2);
      ST_ID3:                        addrSel = idOffset(BYTE_MODE, 2'd3);
      default:                       addrSel = 12'h000;
    endcase
  end

  always_comb begin
    case (strb.step)
      ST_PRE_RST, ST_EXIT: cmdSel = CMD_RESET;
      ST_UNL_A:            cmdSel = CMD_UNLOCK1;
      ST_UNL_B:            cmdSel = CMD_UNLOCK2;
      ST_AUTO:             cmdSel = CMD_IDENTRY;
      default:             cmdSel = 8'h00;
    endcase
  end

  assign memAddr   = ADDR_W'(addrSel);
  assign memWdata  = DATA_W'(cmdSel);
  assign memWe     = strb.req & strb.isWrite;
  assign memRe     = strb.req & ~strb.isWrite;
  assign baseMatch = (memRdata == baseline);
  assign pollLast  = (pollCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) baseline <= '0;
    else if (strb.loadBase) baseline <= memRdata;
  end

  for (genvar k = 0; k < 4; k++) begin : g_idReg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idWords[k] <= '1;
      else if (strb.presetIds) idWords[k] <= '1;
      else if (strb.loadId[k]) idWords[k] <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pollCnt <= '0;
    else if (strb.clrCnt) pollCnt <= '0;
    else if (strb.incCnt) pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timedOut <= 1'b0;
    else if (strb.clrTo) timedOut <= 1'b0;
    else if (strb.setTo) timedOut <= 1'b1;
  end

endmodule

// File: rtl/nor_id_query.sv
module nor_id_query
  import nor_id_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter bit BYTE_MODE   = 1'b0,
  parameter int RETRY_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [DATA_W-1:0] idVendor,
  output logic [DATA_W-1:0] idDev0,
  output logic [DATA_W-1:0] idDev1,
  output logic [DATA_W-1:0] idDev2,
  output logic              done,
  output logic              timedOut
);

  ctrl_strb_t             strb;
  logic                   baseMatch;
  logic                   pollLast;
  logic [3:0][DATA_W-1:0] idWords;

  nor_id_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .memAck    (memAck),
    .baseMatch (baseMatch),
    .pollLast  (pollLast),
    .strb      (strb),
    .done      (done)
  );

  nor_id_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BYTE_MODE   (BYTE_MODE),
    .RETRY_LIMIT (RETRY_LIMIT)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memWe     (memWe),
    .memRe     (memRe),
    .idWords   (idWords),
    .baseMatch (baseMatch),
    .pollLast  (pollLast),
    .timedOut  (timedOut)
  );

  assign idVendor = idWords[0];
  assign idDev0   = idWords[1];
  assign idDev1   = idWords[2];
  assign idDev2   = idWords[3];

endmodule

// File: rtl/nor_id_query_chk.sv
module nor_id_query_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memWe,
  input logic              memRe,
  input logic              memAck,
  input logic              done,
  input logic              timedOut
);

  a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(memWe && memRe));

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((memWe || memRe) && !memAck) |=>
      ((memWe == $past(memWe)) && (memRe == $past(memRe)) &&
       $stable(memAddr) && $stable(memWdata)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!memWe && !memRe));

  a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timedOut) |-> done);

  a_r8_timeout_held: assert property (@(posedge clk) disable iff (!rst_n)
    (timedOut && !start) |=> timedOut);

endmodule

bind nor_id_query nor_id_query_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memWe    (memWe),
  .memRe    (memRe),
  .memAck   (memAck),
  .done     (done),
  .timedOut (timedOut)
);

// File: tb/nor_id_query_tb_top.sv
module flash_model #(
  parameter bit BYTE_MODE = 1'b0,
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               we,
  input  logic               re,
  output logic               ack,
  output logic [DW-1:0]      rdata,
  input  int                 pollDelay,
  input  logic [DW-1:0]      arrayWord,
  input  logic [3:0][DW-1:0] idTab
);
  logic idMode;
  int   pend;

  function automatic logic [DW-1:0] idLook(input logic [AW-1:0] a);
    int m;
    m = BYTE_MODE ? 2 : 1;
    if (a == 0)                 return idTab[0];
    if (int'(a) == 1 * m)       return idTab[1];
    if (int'(a) == 14 * m)      return idTab[2];
    if (int'(a) == 15 * m)      return idTab[3];
    return 16'hDEAD;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0; idMode <= 1'b0; pend <= 0;
    end else begin
      ack <= (we | re) & ~ack;
      if ((we | re) && !ack) begin
        if (we) begin
          if (wdata == 16'h00F0) begin
            pend <= idMode ? pollDelay : 0;
            idMode <= 1'b0;
          end else if (wdata == 16'h0090) idMode <= 1'b1;
        end else if (idMode) rdata <= idLook(addr);
        else if (pend > 0) begin
          pend  <= pend - 1;
          rdata <= ~arrayWord;
        end else rdata <= arrayWord;
      end
    end
  end
endmodule

module nor_id_query_tb_top;
  localparam int AW  = 12;
  localparam int DW  = 16;
  localparam int LIM = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic          startA [2];
  logic [AW-1:0] addrA  [2];
  logic [DW-1:0] wdA    [2];
  logic          weA    [2];
  logic          reA    [2];
  logic [DW-1:0] rdA    [2];
  logic          ackA   [2];
  logic [DW-1:0] idA    [2][4];
  logic          doneA  [2];
  logic          toA    [2];
  int            pollDelayA [2];
  logic [DW-1:0] arrA   [2];
  logic [3:0][DW-1:0] tabA [2];

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [28:0] q [2][$];
  bit expDone [2];

  nor_id_query #(.ADDR_W(AW), .DATA_W(DW), .BYTE_MODE(1'b0), .RETRY_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(startA[0]), .memAddr(addrA[0]), .memWdata(wdA[0]),
    .memWe(weA[0]), .memRe(reA[0]), .memRdata(rdA[0]), .memAck(ackA[0]),
    .idVendor(idA[0][0]), .idDev0(idA[0][1]), .idDev1(idA[0][2]), .idDev2(idA[0][3]),
    .done(doneA[0]), .timedOut(toA[0]));

  nor_id_query #(.ADDR_W(AW), .DATA_W(DW), .BYTE_MODE(1'b1), .RETRY_LIMIT(LIM)) dut_b (
    .clk(clk), .rst_n(rst_n), .start(startA[1]), .memAddr(addrA[1]), .memWdata(wdA[1]),
    .memWe(weA[1]), .memRe(reA[1]), .memRdata(rdA[1]), .memAck(ackA[1]),
    .idVendor(idA[1][0]), .idDev0(idA[1][1]), .idDev1(idA[1][2]), .idDev2(idA[1][3]),
    .done(doneA[1]), .timedOut(toA[1]));

  flash_model #(.BYTE_MODE(1'b0), .AW(AW), .DW(DW)) fm_n (
    .clk(clk), .rst_n(rst_n), .addr(addrA[0]), .wdata(wdA[0]), .we(weA[0]), .re(reA[0]),
    .ack(ackA[0]), .rdata(rdA[0]), .pollDelay(pollDelayA[0]), .arrayWord(arrA[0]), .idTab(tabA[0]));

  flash_model #(.BYTE_MODE(1'b1), .AW(AW), .DW(DW)) fm_b (
    .clk(clk), .rst_n(rst_n), .addr(addrA[1]), .wdata(wdA[1]), .we(weA[1]), .re(reA[1]),
    .ack(ackA[1]), .rdata(rdA[1]), .pollDelay(pollDelayA[1]), .arrayWord(arrA[1]), .idTab(tabA[1]));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Reference model: expected access list, compared as each access completes.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        check(doneA[d] === expDone[d], "R6", "done pulse timing", 32'(doneA[d]), 32'(expDone[d]));
        expDone[d] = 1'b0;
        if (ackA[d]) begin
          if (q[d].size() == 0) begin
            check(1'b0, "R10", "access outside query", 32'(addrA[d]), 32'h0);
          end else begin
            logic [28:0] e;
            e = q[d].pop_front();
            check(weA[d] === e[28] && reA[d] === !e[28], "R10", "access kind",
                  32'({weA[d], reA[d]}), 32'({e[28], !e[28]}));
            check(addrA[d] === e[27:16], "R3", "access address (R2 R4 R6 order)",
                  32'(addrA[d]), 32'(e[27:16]));
            if (e[28]) check(wdA[d] === e[15:0], "R2", "command data (R3 R6)",
                             32'(wdA[d]), 32'(e[15:0]));
            if (q[d].size() == 0) expDone[d] = 1'b1;
          end
        end else if (q[d].size() == 0) begin
          check(!weA[d] && !reA[d], "R10", "request while idle",
                32'({weA[d], reA[d]}), 32'h0);
        end
      end
    end
  end

  task automatic push(input int d, input bit w, input logic [11:0] a, input logic [15:0] v);
    q[d].push_back({w, a, v});
  endtask

  task automatic buildQ(input int d, input bit byteM, input int delay);
    logic [11:0] sa, sb;
    int n;
    sa = byteM ? 12'hAAA : 12'h555;
    sb = byteM ? 12'h555 : 12'h2AA;
    push(d, 1, sa, 16'h00F0);
    push(d, 0, 12'h000, 16'h0);
    push(d, 1, sa, 16'h00AA);
    push(d, 1, sb, 16'h0055);
    push(d, 1, sa, 16'h0090);
    push(d, 0, 12'h000, 16'h0);
    push(d, 0, byteM ? 12'h002 : 12'h001, 16'h0);
    push(d, 0, byteM ? 12'h01C : 12'h00E, 16'h0);
    push(d, 0, byteM ? 12'h01E : 12'h00F, 16'h0);
    push(d, 1, 12'h000, 16'h00F0);
    n = (delay + 1 > LIM) ? LIM : delay + 1;
    for (int i = 0; i < n; i++) push(d, 0, 12'h000, 16'h0);
  endtask

  task automatic runQuery(input int d, input int delay, input bit expTo, input bit midStart);
    pollDelayA[d] = delay;
    buildQ(d, d == 1, delay);
    @(negedge clk); startA[d] = 1'b1;
    @(negedge clk); startA[d] = 1'b0;
    for (int k = 0; k < 4; k++)
      check(idA[d][k] === '1, "R5", "ID preset on start", 32'(idA[d][k]), 32'hFFFF);
    check(toA[d] === 1'b0, "R8", "timeout cleared by start", 32'(toA[d]), 32'h0);
    if (midStart) begin
      repeat (7) @(negedge clk);
      startA[d] = 1'b1;             // R9: ignored while busy
      @(negedge clk); startA[d] = 1'b0;
    end
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (doneA[d]) break;
    end
    check(doneA[d] === 1'b1, "R6", "query ended", 32'(doneA[d]), 32'h1);
    check(q[d].size() == 0, "R9", "accesses left after done", 32'(q[d].size()), 32'h0);
    for (int k = 0; k < 4; k++)
      check(idA[d][k] === tabA[d][k], "R4", "ID word", 32'(idA[d][k]), 32'(tabA[d][k]));
    check(toA[d] === expTo, "R7", "timeout flag", 32'(toA[d]), 32'(expTo));
    repeat (5) @(negedge clk);
    check(toA[d] === expTo, "R8", "timeout flag held", 32'(toA[d]), 32'(expTo));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
    finish();
  end

  initial begin
    rst_n = 1'b0;
    for (int d = 0; d < 2; d++) begin
      startA[d] = 1'b0; expDone[d] = 1'b0; pollDelayA[d] = 0;
    end
    arrA[0] = 16'h1234; arrA[1] = 16'h5A5A;
    tabA[0] = {16'h2201, 16'h2220, 16'h227E, 16'h0001};
    tabA[1] = {16'h2233, 16'h2212, 16'h22A8, 16'h00C2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check(!weA[d] && !reA[d], "R1", "no request after reset", 32'({weA[d], reA[d]}), 32'h0);
      check(doneA[d] === 1'b0 && toA[d] === 1'b0, "R1", "flags after reset",
            32'({doneA[d], toA[d]}), 32'h0);
      for (int k = 0; k < 4; k++)
        check(idA[d][k] === '1, "R1", "ID reset value", 32'(idA[d][k]), 32'hFFFF);
    end
    runQuery(0, 2, 1'b0, 1'b0);    // native, short poll
    runQuery(0, 20, 1'b1, 1'b1);   // native, timeout, start while busy
    runQuery(0, LIM - 1, 1'b0, 1'b0); // native, match on last allowed read
    runQuery(1, 0, 1'b0, 1'b0);    // byte map, immediate match
    runQuery(1, 30, 1'b1, 1'b0);   // byte map, timeout
    runQuery(1, 3, 1'b0, 1'b1);    // byte map, timeout cleared, start while busy
    finish();
  end
endmodule